// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block sits behind a byte-wide host bridge and turns a stream of one-byte commands into accesses to a small bank of 8-bit registers. In each command byte, the high nibble is an opcode and the low nibble is an operand. A full 8-bit register address is built from two address commands, one for each nibble. A data byte is built in two steps: one command latches the low data nibble, and a second command supplies the high nibble and commits the write.

Reads use a separate command. Each read answers with one byte on a valid/ready response port. The read can move the address up or down by one after the access, so a host can walk through consecutive registers without resending the address. Reads and writes to the same address reach different registers. Written values appear on `wr_regs` and drive the neighbouring logic. Read values come from the `rd_bank` status inputs that the neighbours provide. The bank covers addresses below `NREG`, which is 16 by default. Reads above that range complete normally and return 0xFF. Writes above that range are dropped.

Top module: `nib_reg_decoder`

## Requirements
- R1: After a synchronous active-high reset, the address is 0, the pending low data nibble is 0, every byte of `wr_regs` is 0, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. Opcode 0x0 (bits [7:4]) loads the operand (bits [3:0]) into address bits [3:0]. Opcode 0x1 loads the operand into address bits [7:4]. The other address nibble is left as it was.
- R3: Opcode 0x2 latches the operand as the low data nibble. Opcode 0x3 writes the byte {operand, latched nibble} to the register at the current address, if that address is below `NREG`. The new value is visible on `wr_regs[8*a+7:8*a]` after the clock edge that takes the command.
- R4: An opcode 0x3 write to an address of `NREG` or above changes no byte of `wr_regs`.
- R5: Opcode 0x4 reads the current address. `rsp_valid` rises one cycle after the command is taken. `rsp_data` is `rd_bank[8*a+7:8*a]` for an address below `NREG`, and 0xFF otherwise.
- R6: On opcode 0x4, if operand bit 0 is set, the address changes after the read: it decrements if operand bit 1 is set and increments if bit 1 is clear. The arithmetic wraps modulo 256. If bit 0 is clear, the address is kept.
- R7: While `rsp_valid` is high, `cmd_ready` is low. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is sampled high, and `rsp_valid` then falls.
- R8: Opcodes 0x5 to 0xF are taken and have no effect on the address, the latched data nibble, the registers or the response port.
- R9: A write leaves the address and the latched low nibble unchanged, so a later 0x3 command reuses the same low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_byte | input | 8 | Opcode in [7:4], operand in [3:0] |
| rd_bank | input | NREG*8 | Read-side register values, byte a at [8a+7:8a] |
| wr_regs | output | NREG*8 | Write-side register contents, byte a at [8a+7:8a] |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | 8 | Read response byte |

## Verification
The bench sweeps all 256 addresses. At each address it loads the address, writes a byte derived from the address, checks the full write bank, and then reads with one of four operand variants in rotation. Addresses below 16 show whether the write landed in the right byte. Addresses at 16 and above show whether out-of-range writes are dropped and out-of-range reads return 0xFF. A follow-up plain read after each read tells the four variants apart: no change, increment, bit 1 without bit 0 (no change), and decrement. Separate runs check wrap-around at 0 and 255, every ignored opcode with several operands, reuse of the latched low nibble, and a response held back by `rsp_ready`.

// File: rtl/nib_reg_decoder.sv
module nib_reg_decoder #(
  parameter int NREG = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_byte,
  input  logic [NREG*8-1:0] rd_bank,
  output logic [NREG*8-1:0] wr_regs,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [8:0] LIM = 9'(NREG);

  logic [7:0] addr;
  logic [3:0] lo_nib;

  wire       take  = cmd_valid && cmd_ready;
  wire [3:0] opc   = cmd_byte[7:4];
  wire [3:0] opd   = cmd_byte[3:0];
  wire       in_rng = ({1'b0, addr} < LIM);
  wire [IW-1:0] idx = addr[IW-1:0];
  wire [7:0] rd_pick = in_rng ? rd_bank[{idx, 3'b000} +: 8] : 8'hFF;
  wire       do_wr = take && (opc == 4'h3) && in_rng;

  assign cmd_ready = !rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= 8'h00;
    end else if (take) begin
      case (opc)
        4'h0: addr[3:0] <= opd;
        4'h1: addr[7:4] <= opd;
        4'h4: if (opd[0]) addr <= opd[1] ? addr - 8'd1 : addr + 8'd1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          lo_nib <= 4'h0;
    else if (take && opc == 4'h2)     lo_nib <= opd;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                q <= 8'h00;
      else if (do_wr && idx == IW'(i))        q <= {opd, lo_nib};
    end
    assign wr_regs[i*8 +: 8] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (take && opc == 4'h4) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_pick;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R5
  read_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (take && opc == 4'h4) |=> rsp_valid);

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R6
  addr_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (take && opc == 4'h4 && opd[1:0] == 2'b01) |=> (addr == $past(addr) + 8'd1));

  // R6
  addr_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (take && opc == 4'h4 && opd[1:0] == 2'b11) |=> (addr == $past(addr) - 8'd1));

  // R4
  far_write_chk: assert property (@(posedge clk) disable iff (rst)
    (take && opc == 4'h3 && !in_rng) |=> $stable(wr_regs));

  // R8
  ignored_op_chk: assert property (@(posedge clk) disable iff (rst)
    (take && opc >= 4'h5) |=> ($stable(addr) && $stable(lo_nib) && $stable(wr_regs)));

  // R9
  write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (take && opc == 4'h3) |=> ($stable(addr) && $stable(lo_nib)));
endmodule

// File: tb/nib_reg_decoder_bench.sv
module nib_reg_decoder_bench;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic rsp_ready = 1'b0;
  logic cmd_ready, rsp_valid;
  logic [7:0] rsp_data;
  logic [NREG*8-1:0] rd_bank, wr_regs;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] m_addr;
  logic [3:0] m_lo;
  logic [NREG*8-1:0] m_regs;

  always #4 clk = ~clk;

  nib_reg_decoder #(.NREG(NREG)) u_nib_reg_decoder (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .rd_bank(rd_bank), .wr_regs(wr_regs),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  function automatic logic [7:0] rd_val(input int i);
    return 8'((i * 29 + 3) & 255);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    return (a < NREG) ? rd_val(int'(a)) : 8'hFF;
  endfunction

  for (genvar i = 0; i < NREG; i++) begin : g_rd
    assign rd_bank[i*8 +: 8] = rd_val(i);
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
    m_addr = a;
  endtask

  task automatic write_byte(input logic [7:0] d, input string req);
    send({4'h2, d[3:0]});
    m_lo = d[3:0];
    send({4'h3, d[7:4]});
    if (m_addr < NREG) m_regs[m_addr*8 +: 8] = d;
    chk(wr_regs == m_regs, req, wr_regs, m_regs);
  endtask

  task automatic rd(input logic [3:0] op, input string req, input bit stall);
    logic [7:0] e;
    e = exp_rd(m_addr);
    send({4'h4, op});
    chk(rsp_valid === 1'b1 && rsp_data == e, req, {rsp_valid, rsp_data}, {1'b1, e});
    if (op[0]) m_addr = op[1] ? m_addr - 8'd1 : m_addr + 8'd1;
    if (stall) begin
      @(negedge clk);
      // R7 held response, commands blocked
      chk(rsp_valid && rsp_data == e && !cmd_ready, "R7", {rsp_valid, cmd_ready, rsp_data}, {2'b10, e});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (stall) chk(!rsp_valid && cmd_ready, "R7", {rsp_valid, cmd_ready}, 2'b01);
  endtask

  initial begin
    m_addr = 8'h00;
    m_lo = 4'h0;
    m_regs = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!rsp_valid && cmd_ready && wr_regs == '0, "R1", {rsp_valid, cmd_ready, wr_regs}, {2'b01, 128'h0});
    rd(4'h0, "R1", 1'b1);

    for (int a = 0; a < 256; a++) begin
      logic [3:0] op;
      set_addr(8'(a));
      write_byte(8'(a) ^ 8'hA5, (a < NREG) ? "R3" : "R4");
      case (a % 4)
        0: op = 4'h0;
        1: op = 4'h1;
        2: op = 4'h2;
        default: op = 4'h3;
      endcase
      rd(op, "R5", (a % 37) == 0);
      rd(4'h0, "R6", 1'b0);
    end

    // R6 wrap at both ends
    set_addr(8'h00);
    rd(4'h3, "R6", 1'b0);
    rd(4'h0, "R6", 1'b0);
    rd(4'h1, "R6", 1'b0);
    rd(4'h0, "R6", 1'b0);

    // R2 partial address loads keep the other nibble
    set_addr(8'h37);
    send(8'h05);
    m_addr = 8'h35;
    rd(4'h0, "R2", 1'b0);
    send(8'h10);
    m_addr = 8'h05;
    rd(4'h0, "R2", 1'b0);

    // R8 ignored opcodes
    set_addr(8'h09);
    send(8'h2C);
    m_lo = 4'hC;
    for (int o = 5; o < 16; o++) begin
      send({4'(o), 4'(o * 3)});
      send({4'(o), 4'hF});
      chk(wr_regs == m_regs && !rsp_valid, "R8", {rsp_valid, wr_regs}, {1'b0, m_regs});
      rd(4'h0, "R8", 1'b0);
    end
    send(8'h36);
    m_regs[m_addr*8 +: 8] = {4'h6, m_lo};
    chk(wr_regs == m_regs, "R8", wr_regs, m_regs);

    // R9 low nibble reused, address kept
    send(8'h3B);
    m_regs[m_addr*8 +: 8] = {4'hB, m_lo};
    chk(wr_regs == m_regs, "R9", wr_regs, m_regs);
    rd(4'h0, "R9", 1'b0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule